// File: doc/BRIEF.md
# Supervisor Interrupt Aggregator and Pin Driver

This block merges three supervisor events into one interrupt/reset output pin. The three events are a watchdog timeout, a power-fail detect and a clock alarm. Each event sets a sticky cause flag. Each event also has its own enable bit that lets it drive the pin. A host reads the cause flags through a small bus port. A read that runs to completion clears the flags. A read that is aborted, or any write, leaves them in place.

A programmable output stage shapes the pin:

- **Timing mode:** level mode holds the pin active until the flags are cleared. Pulse mode gives a fixed-width pulse long enough to reset a host processor.
- **Drive type:** active-high push-pull, or active-low open-drain.
- **Backup mode:** while the system runs on battery, only the alarm may reach the pin, and only when a separate backup-alarm enable is set. In that state the pin is always open-drain, active low.

Top module: `sup_irq_pin`

## Requirements
- R1: After reset, the flags and the control register read 0, and the pin is released (`pin_oe`=0, `pin_out`=0).
- R2: An event strobe sets its flag at the next clock edge, whatever its enable bit. The flag register, read at `FLAG_ADDR`, holds watchdog in bit 0, power-fail in bit 1 and alarm in bit 2.
- R3: An access that keeps `bus_sel` high with `bus_we`=1 and `bus_addr`=`FLAG_ADDR` on every cycle is a complete read. All flags clear at the first edge that samples `bus_sel` low after such an access.
- R4: An access in which `bus_we` is low on any cycle, or in which the address leaves `FLAG_ADDR`, does not clear the flags.
- R5: An event sampled on the same edge as a clear leaves its flag set.
- R6: A cycle with `bus_sel`=1, `bus_we`=0 and `bus_addr`=`CTRL_ADDR` writes the control register, which reads back at `CTRL_ADDR` in the next cycle. Its bits are:
  - bit 0: watchdog enable
  - bit 1: power-fail enable
  - bit 2: alarm enable
  - bit 3: backup-alarm enable
  - bit 4: drive high (push-pull)
  - bit 5: pulse mode
- R7: In level mode, the pin is active whenever a flag and its enable are both set.
- R8: In pulse mode, a strobe with its enable set, seen while no pulse runs, makes the pin active for exactly `PULSE_W` cycles starting the next cycle. Strobes during a pulse neither extend nor restart it.
- R9: In push-pull drive, `pin_oe`=1 and `pin_out` equals the active state. In open-drain drive, `pin_out`=0 and `pin_oe` equals the active state.
- R10: While `backup_mode`=1, the watchdog and power-fail sources cannot drive the pin. The alarm drives it only when alarm enable and backup-alarm enable are both set. The drive is open-drain regardless of bit 4.
- R11: Reads at any address other than `FLAG_ADDR` and `CTRL_ADDR` return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdog_evt | input | 1 | Watchdog timeout strobe |
| pfail_evt | input | 1 | Power-fail strobe |
| alarm_evt | input | 1 | Clock alarm strobe |
| backup_mode | input | 1 | System runs from backup supply |
| bus_sel | input | 1 | Access in progress |
| bus_we | input | 1 | 1 = read, 0 = write |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data |
| pin_out | output | 1 | Pin data value |
| pin_oe | output | 1 | Pin output enable |

## Verification
The bench builds the block with `PULSE_W`=5 instead of the default, which is a pulse of several million cycles. With 5, it can count the pulse edge by edge and inject a retrigger in the middle of it. The two register addresses keep their defaults in the 4-bit space. That leaves other addresses free, so the read-zero rule can be exercised. It also means a write aimed at the flag address can be tried as a non-clearing access. `PULSE_W`=1 selects a one-flop variant that this bench does not build.

// File: rtl/sup_irq_pkg.sv
package sup_irq_pkg;
   localparam int N_SRC  = 3;
   localparam int CTRL_W = 6;
   localparam int SRC_WD = 0;
   localparam int SRC_PF = 1;
   localparam int SRC_AL = 2;

   typedef struct packed {
      logic pulse;      // bit 5
      logic drv_high;   // bit 4
      logic alm_bk_en;  // bit 3
      logic alm_en;     // bit 2
      logic pf_en;      // bit 1
      logic wd_en;      // bit 0
   } irq_ctrl_t;

   // sources allowed to reach the pin under the present supply state
   function automatic logic [N_SRC-1:0] src_mask(irq_ctrl_t c, logic backup);
      logic [N_SRC-1:0] m;
      m = '0;
      if (backup) begin
         m[SRC_AL] = c.alm_en & c.alm_bk_en;
      end else begin
         m[SRC_WD] = c.wd_en;
         m[SRC_PF] = c.pf_en;
         m[SRC_AL] = c.alm_en;
      end
      return m;
   endfunction
endpackage

// File: rtl/sup_irq_busif.sv
module sup_irq_busif
   import sup_irq_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter int FLAG_ADDR = 6,
   parameter int CTRL_ADDR = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [N_SRC-1:0]  flags,
   output logic [DATA_W-1:0] bus_rdata,
   output irq_ctrl_t         ctrl,
   output logic              clr
);
   localparam logic [ADDR_W-1:0] FA = FLAG_ADDR[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] CA = CTRL_ADDR[ADDR_W-1:0];

   logic prev_sel_q, bad_q;
   logic hit_flag, hit_ctrl;

   assign hit_flag = (bus_addr == FA);
   assign hit_ctrl = (bus_addr == CA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_sel_q <= 1'b0;
         bad_q      <= 1'b0;
         ctrl       <= '0;
      end else begin
         prev_sel_q <= bus_sel;
         if (bus_sel)
            bad_q <= (prev_sel_q & bad_q) | ~bus_we | ~hit_flag;
         if (bus_sel && !bus_we && hit_ctrl)
            ctrl <= irq_ctrl_t'(bus_wdata[CTRL_W-1:0]);
      end
   end

   // a read that ran to the end unbroken clears on the closing edge
   assign clr = prev_sel_q & ~bus_sel & ~bad_q;

   always_comb begin
      bus_rdata = '0;
      if (hit_flag)
         bus_rdata[N_SRC-1:0] = flags;
      else if (hit_ctrl)
         bus_rdata[CTRL_W-1:0] = ctrl;
   end
endmodule

// File: rtl/sup_irq_flags.sv
module sup_irq_flags #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic         clr,
   output logic [N-1:0] flags
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flags[i] <= 1'b0;
         else if (evt[i])
            flags[i] <= 1'b1;   // event beats a coincident clear
         else if (clr)
            flags[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/sup_irq_pulse.sv
module sup_irq_pulse #(
   parameter int PULSE_W = 25_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic active
);
   localparam int CW = $clog2(PULSE_W + 1);

   if (PULSE_W == 1) begin : g_single
      logic act_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) act_q <= 1'b0;
         else        act_q <= trig & ~act_q;
      end
      assign active = act_q;
   end else begin : g_count
      localparam logic [CW-1:0] LOAD = CW'(PULSE_W);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q <= '0;
         else if (cnt_q == '0) begin
            if (trig) cnt_q <= LOAD;
         end else
            cnt_q <= cnt_q - 1'b1;
      end
      assign active = (cnt_q != '0);
   end
endmodule

// File: rtl/sup_irq_drive.sv
module sup_irq_drive (
   input  logic active,
   input  logic drv_high,
   input  logic backup_mode,
   output logic pin_out,
   output logic pin_oe
);
   logic push_pull;
   assign push_pull = drv_high & ~backup_mode;
   assign pin_out   = push_pull & active;
   assign pin_oe    = push_pull | active;
endmodule

// File: rtl/sup_irq_pin.sv
module sup_irq_pin
   import sup_irq_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter int FLAG_ADDR = 6,
   parameter int CTRL_ADDR = 7,
   parameter int PULSE_W   = 25_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wdog_evt,
   input  logic              pfail_evt,
   input  logic              alarm_evt,
   input  logic              backup_mode,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              pin_out,
   output logic              pin_oe
);
   if (PULSE_W < 1) begin : g_bad_pw
      $error("PULSE_W must be at least 1");
   end
   if (DATA_W < CTRL_W) begin : g_bad_dw
      $error("DATA_W too narrow for control register");
   end
   if (FLAG_ADDR == CTRL_ADDR) begin : g_bad_addr
      $error("flag and control addresses collide");
   end
   if (FLAG_ADDR >= (1 << ADDR_W) || CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_range
      $error("register address outside ADDR_W space");
   end

   logic [N_SRC-1:0] src_evt, flags_q, mask;
   irq_ctrl_t        ctrl_q;
   logic             clr, trig, pulse_act, level_req, active;

   assign src_evt[SRC_WD] = wdog_evt;
   assign src_evt[SRC_PF] = pfail_evt;
   assign src_evt[SRC_AL] = alarm_evt;

   sup_irq_busif #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .FLAG_ADDR(FLAG_ADDR), .CTRL_ADDR(CTRL_ADDR)
   ) u_bus (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .flags(flags_q),
      .bus_rdata(bus_rdata), .ctrl(ctrl_q), .clr(clr)
   );

   sup_irq_flags #(.N(N_SRC)) u_flags (
      .clk(clk), .rst_n(rst_n), .evt(src_evt), .clr(clr), .flags(flags_q)
   );

   assign mask      = src_mask(ctrl_q, backup_mode);
   assign trig      = ctrl_q.pulse & |(src_evt & mask);
   assign level_req = |(flags_q & mask);

   sup_irq_pulse #(.PULSE_W(PULSE_W)) u_pulse (
      .clk(clk), .rst_n(rst_n), .trig(trig), .active(pulse_act)
   );

   assign active = ctrl_q.pulse ? pulse_act : level_req;

   sup_irq_drive u_drv (
      .active(active), .drv_high(ctrl_q.drv_high), .backup_mode(backup_mode),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );
endmodule

// File: rtl/sup_irq_chk.sv
module sup_irq_chk
   import sup_irq_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter int CTRL_ADDR = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [N_SRC-1:0]  src_evt,
   input logic [N_SRC-1:0]  flags_q,
   input logic              clr,
   input irq_ctrl_t         ctrl_q,
   input logic              backup_mode,
   input logic              pin_out,
   input logic              pin_oe
);
   localparam logic [ADDR_W-1:0] CA = CTRL_ADDR[ADDR_W-1:0];

   p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (src_evt != '0) |=> ((flags_q & $past(src_evt)) == $past(src_evt)));

   p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && src_evt == '0) |=> (flags_q == '0));

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && src_evt == '0) |=> $stable(flags_q));

   p_ctrl_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && bus_addr == CA) |=>
         (ctrl_q == $past(bus_wdata[CTRL_W-1:0])));

   p_pp_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.drv_high && !backup_mode) |-> pin_oe);

   p_od_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctrl_q.drv_high && !backup_mode) |-> !pin_out);

   p_bk_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (backup_mode && !ctrl_q.alm_bk_en && !ctrl_q.pulse) |-> !pin_oe);
endmodule

bind sup_irq_pin sup_irq_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .src_evt(src_evt),
   .flags_q(flags_q), .clr(clr), .ctrl_q(ctrl_q), .backup_mode(backup_mode),
   .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/tb_sup_irq_pin.sv
`timescale 1ns/1ps
module tb_sup_irq_pin;
   localparam int AW = 4, DW = 8, FA = 6, CA = 7, PW = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wdog_evt = 0, pfail_evt = 0, alarm_evt = 0, backup_mode = 0;
   logic bus_sel = 0, bus_we = 1;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic pin_out, pin_oe;

   int total = 0, bad = 0;

   sup_irq_pin #(.ADDR_W(AW), .DATA_W(DW), .FLAG_ADDR(FA), .CTRL_ADDR(CA),
                 .PULSE_W(PW)) dut (.*);

   always #4 clk = ~clk;

   // ---- behavioural reference ----
   int m_flags, m_ctrl, m_cnt;
   bit m_prev, m_bad;

   function automatic int msk(int c, bit bk);
      if (bk) return ((c >> 2) & (c >> 3) & 1) ? 4 : 0;
      return c & 7;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_flags = 0; m_ctrl = 0; m_cnt = 0; m_prev = 0; m_bad = 0;
      end else begin
         int ev, n_flags, n_ctrl, n_cnt;
         bit clr, n_bad;
         ev  = {29'd0, alarm_evt, pfail_evt, wdog_evt};
         clr = m_prev && !bus_sel && !m_bad;
         n_flags = clr ? (ev) : (m_flags | ev);
         n_bad = m_bad;
         if (bus_sel) n_bad = (m_prev && m_bad) || !bus_we || (int'(bus_addr) != FA);
         n_cnt = m_cnt;
         if (m_cnt > 0) n_cnt = m_cnt - 1;
         else if (((m_ctrl >> 5) & 1) != 0 && (ev & msk(m_ctrl, backup_mode)) != 0) n_cnt = PW;
         n_ctrl = m_ctrl;
         if (bus_sel && !bus_we && int'(bus_addr) == CA) n_ctrl = int'(bus_wdata) & 63;
         m_flags = n_flags; m_ctrl = n_ctrl; m_cnt = n_cnt; m_prev = bus_sel; m_bad = n_bad;
      end
   end

   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         bit act, pp;
         int exp_rd;
         act = ((m_ctrl >> 5) & 1) != 0 ? (m_cnt > 0)
                                         : ((m_flags & msk(m_ctrl, backup_mode)) != 0);
         pp  = ((m_ctrl >> 4) & 1) != 0 && !backup_mode;
         exp_rd = (int'(bus_addr) == FA) ? m_flags : (int'(bus_addr) == CA) ? m_ctrl : 0;
         chk("R7 R8 R9 R10 pin_out", int'(pin_out), int'(pp && act));
         chk("R7 R8 R9 R10 pin_oe", int'(pin_oe), int'(pp || act));
         chk("R2 R6 R11 rdata", int'(bus_rdata), exp_rd);
      end
   end

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic nclk(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(int a, int d);
      bus_sel = 1; bus_we = 0; bus_addr = AW'(a); bus_wdata = DW'(d);
      nclk(); bus_sel = 0; bus_we = 1; nclk();
   endtask

   task automatic bus_read(int a);
      bus_sel = 1; bus_we = 1; bus_addr = AW'(a);
      nclk(2); bus_sel = 0; nclk();
   endtask

   task automatic pulse_evt(int which);
      {alarm_evt, pfail_evt, wdog_evt} = 3'(which);
      nclk(); {alarm_evt, pfail_evt, wdog_evt} = 3'b000; nclk();
   endtask

   initial begin
      #(8 * 200000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      nclk(3); rst_n = 1; nclk();
      // R1 reset state
      chk("R1 pin_oe", int'(pin_oe), 0);
      chk("R1 pin_out", int'(pin_out), 0);
      bus_addr = AW'(FA); nclk();
      chk("R1 flags", int'(bus_rdata), 0);
      bus_addr = AW'(CA); nclk();
      chk("R1 ctrl", int'(bus_rdata), 0);
      bus_addr = 3; nclk();
      chk("R11 other addr", int'(bus_rdata), 0);

      // R2 flags set without enables
      bus_addr = AW'(FA);
      pulse_evt(3);
      chk("R2 flags", int'(bus_rdata), 3);
      chk("R7 no enable", int'(pin_oe), 0);

      // R6 control write, level open-drain with watchdog enabled
      bus_write(CA, 8'h01);
      bus_addr = AW'(CA); nclk();
      chk("R6 readback", int'(bus_rdata), 1);
      chk("R7 level active oe", int'(pin_oe), 1);
      chk("R9 open-drain out", int'(pin_out), 0);

      // R4 aborted read and write to flag address
      bus_addr = AW'(FA); bus_sel = 1; bus_we = 1; nclk();
      bus_we = 0; nclk(); bus_sel = 0; bus_we = 1; nclk();
      chk("R4 aborted read", int'(bus_rdata), 3);
      bus_write(FA, 0);
      chk("R4 write keeps", int'(bus_rdata), 3);

      // R3 complete read clears
      bus_read(FA);
      chk("R3 cleared", int'(bus_rdata), 0);
      chk("R3 pin released", int'(pin_oe), 0);

      // R5 event coincident with clear
      pulse_evt(4);
      bus_sel = 1; bus_we = 1; nclk();
      bus_sel = 0; alarm_evt = 1; nclk();
      alarm_evt = 0; nclk();
      chk("R5 event wins", int'(bus_rdata), 4);
      bus_read(FA);

      // R9 push-pull
      bus_write(CA, 8'h11); nclk();
      chk("R9 pp idle oe", int'(pin_oe), 1);
      chk("R9 pp idle out", int'(pin_out), 0);
      pulse_evt(1);
      chk("R9 pp active out", int'(pin_out), 1);
      bus_read(FA);
      chk("R9 pp cleared out", int'(pin_out), 0);

      // R8 pulse mode, open-drain, alarm
      bus_write(CA, 8'h24);
      alarm_evt = 1; nclk(); alarm_evt = 0;
      for (int k = 1; k <= 7; k++) begin
         chk($sformatf("R8 pulse cycle %0d", k), int'(pin_oe), (k <= PW) ? 1 : 0);
         if (k == 2) alarm_evt = 1;
         if (k == 3) alarm_evt = 0;
         nclk();
      end
      bus_read(FA);

      // R10 backup masking and forced open-drain
      bus_write(CA, 8'h17);
      pulse_evt(1);
      backup_mode = 1; nclk();
      chk("R10 wd masked oe", int'(pin_oe), 0);
      chk("R10 forced od out", int'(pin_out), 0);
      pulse_evt(4);
      chk("R10 alarm no bk_en", int'(pin_oe), 0);
      bus_write(CA, 8'h1F); nclk();
      chk("R10 alarm bk oe", int'(pin_oe), 1);
      chk("R10 alarm bk out", int'(pin_out), 0);
      backup_mode = 0; nclk();
      chk("R10 back to pp", int'(pin_out), 1);
      bus_read(FA);
      chk("R3 final clear", int'(bus_rdata), 0);
      nclk(2);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule